// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Eight-Word Queue

This block takes 32-bit avionics data words from a host as two 16-bit halves, queues up to eight complete words, and sends each one as a bipolar return-to-zero bit stream on a pair of line outputs (`tx_one`, `tx_zero`). Each bit cell lasts ten clocks, so the system clock must run at ten times the bit rate. The block computes a parity bit and places it in the final bit position. The parity sense and the word length (32 or 25 bits) are set by two level inputs, which are sampled when a word starts.

The host drives `host_data` and pulses `load_first` to capture ARINC bits 1 to 16. It then drives the upper half and pulses `load_second`, which captures bits 17 to 32 and pushes the assembled word into the queue. The serializer takes a word from the queue as soon as one is waiting and the line is free. After every word it holds a null of four bit times. `queue_empty` shows when the queue has drained. `loop_bit` carries the bit value being sent, at logic level, so that a local receiver can use it as a self-test source.

Top module: `a429_tx_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `tx_one`, `tx_zero` and `loop_bit` are 0 and `queue_empty` is 1.
- R2: A `load_first` pulse captures `host_data[15:0]` as ARINC bits 16..1, with bit 0 of the bus being ARINC bit 1. A `load_second` pulse takes `host_data[15:0]` as ARINC bits 32..17, combines it with the captured half, and queues the word.
- R3: The queue holds at most eight words. A `load_second` pulse while eight words are queued is ignored: no word is lost or overwritten, and the extra word is never sent.
- R4: `queue_empty` goes low on the clock after a push into an empty queue. It returns high on the clock on which the last queued word is taken for sending.
- R5: When the line is idle, the first bit cell of a queued word begins one clock after the push edge. Words are sent in push order. The bits go out as ARINC bits 8 down to 1 (the label, most significant bit first), then ARINC bits 9 upward.
- R6: Each bit cell is ten clocks long. A one drives `tx_one` high for the first five clocks, and a zero drives `tx_zero` high for the first five clocks. Both outputs are low for the last five clocks, and they are never high together.
- R7: The last bit of the word is parity. With `par_even`=0 the total number of ones in the sent word is odd. With `par_even`=1 it is even.
- R8: With `len32`=1 a word is 32 bits: ARINC bits 1..31 are data and bit 32 is parity. With `len32`=0 a word is 25 bits: bits 1..24 are data and bit 25 is parity. Stored bits 25..32 are then neither sent nor counted in the parity.
- R9: After the last bit cell of a word ends, both line outputs stay low for exactly 40 clocks. A word that is already waiting starts its first cell on the next clock.
- R10: `loop_bit` equals the value of the bit being sent for all ten clocks of its cell, and is 0 outside word transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ten times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 16 | Half-word from the host |
| load_first | input | 1 | Strobe that captures ARINC bits 1..16 |
| load_second | input | 1 | Strobe that captures ARINC bits 17..32 and queues the word |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| len32 | input | 1 | Word length: 1 for 32 bits, 0 for 25 bits |
| tx_one | output | 1 | Line output, high in the first half of a one cell |
| tx_zero | output | 1 | Line output, high in the first half of a zero cell |
| loop_bit | output | 1 | Logic-level copy of the bit being sent |
| queue_empty | output | 1 | High when no word is waiting in the queue |

## Verification
On an idle line, a word pushed at clock edge E puts its first half-cell on the line after edge E+1. Bit k of that word is therefore active after edges E+1+10k through E+5+10k. The bench drives and samples on falling edges. It reads each cell on its first active clock and again five clocks later, when both line outputs must be low and `loop_bit` must still hold the bit. `queue_empty` is read half a clock after the push edge, where it must be low, and again after the take edge, where it must be high. The gap is measured from the end of the last cell to the next active clock, and the expected count there is exactly 40.

// File: rtl/a429_pkg.sv
// Shared types and helpers for the serial avionics word transmitter.
// Assumes a 32-bit word with ARINC bit n stored at index n-1.
package a429_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_GAP
    } tx_state_t;

    // Clears the bits beyond the word length and writes parity into the last bit.
    function automatic logic [WORD_W-1:0] build_frame(
        input logic [WORD_W-1:0] w,
        input logic              l32,
        input logic              even
    );
        logic [WORD_W-1:0] f;
        if (l32) begin
            f = {1'b0, w[30:0]};
            f[31] = (^f) ^ ~even;
        end else begin
            f = {8'h00, w[23:0]};
            f[24] = (^f) ^ ~even;
        end
        return f;
    endfunction

endpackage

// File: rtl/a429_fifo.sv
// Word queue: a circular buffer of DEPTH entries with a head-of-queue read port.
// A push into a full queue is dropped. The caller never pops an empty queue.
module a429_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write; holds no reset because entries are only read once written.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3: a push into a full queue leaves the occupancy unchanged
    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
    // R4: any push leaves the queue non-empty
    a_r4_push_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);

endmodule

// File: rtl/a429_ser.sv
// Bit serializer: takes a word when one is offered and the line is free, then sends
// it as return-to-zero cells of TICKS clocks, label first, followed by a null gap.
// Assumes TICKS is even, so the active half and the null half are equal.
module a429_ser
    import a429_pkg::*;
#(
    parameter int TICKS    = 10,
    parameter int GAP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              avail,
    input  logic [WORD_W-1:0] word,
    input  logic              len32,
    input  logic              par_even,
    output logic              take,
    output logic              tx_one,
    output logic              tx_zero,
    output logic              loop_bit
);
    localparam int TW   = $clog2(TICKS);
    localparam int HALF = TICKS / 2;
    localparam int BW   = $clog2(WORD_W) + 1;

    tx_state_t         state;
    logic [TW-1:0]     tick;
    logic [BW-1:0]     bitn, lastbit;
    logic [WORD_W-1:0] frame;
    logic [4:0]        idx;
    logic              cell_end, gap_done, cur_bit, sending;

    assign cell_end = (tick == TW'(TICKS - 1));
    assign gap_done = (state == ST_GAP) && cell_end && (bitn == BW'(GAP_BITS - 1));
    assign take     = avail && ((state == ST_IDLE) || gap_done);

    // Maps the cell number to the stored bit index: label reversed, then ascending.
    always_comb begin
        if (bitn < BW'(8)) idx = 5'(7 - bitn);
        else               idx = bitn[4:0];
    end

    assign cur_bit  = frame[idx];
    assign sending  = (state == ST_SEND);
    assign tx_one   = sending && (tick < TW'(HALF)) && cur_bit;
    assign tx_zero  = sending && (tick < TW'(HALF)) && !cur_bit;
    assign loop_bit = sending && cur_bit;

    // Cell, bit and gap sequencing; a take has priority and starts a fresh word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tick    <= '0;
            bitn    <= '0;
            lastbit <= '0;
            frame   <= '0;
        end else if (take) begin
            state   <= ST_SEND;
            tick    <= '0;
            bitn    <= '0;
            lastbit <= len32 ? BW'(31) : BW'(24);
            frame   <= build_frame(word, len32, par_even);
        end else begin
            case (state)
                ST_SEND: begin
                    if (cell_end) begin
                        tick <= '0;
                        if (bitn == lastbit) begin
                            state <= ST_GAP;
                            bitn  <= '0;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cell_end) begin
                        tick <= '0;
                        if (bitn == BW'(GAP_BITS - 1)) begin
                            state <= ST_IDLE;
                            bitn  <= '0;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R6: the two line outputs are never high together
    a_r6_exclusive_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_one && tx_zero));
    // R9: no word is taken while a word is still being sent
    a_r9_no_take_midword: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state != ST_SEND));
    // R6: an active half-cell lasts longer than one clock
    a_r6_half_cell_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_one || tx_zero) |=> (tx_one || tx_zero));

endmodule

// File: rtl/a429_tx_top.sv
// Transmitter top: assembles host half-words, queues them, and hands them to the
// serializer. Assumes the clock runs at ten times the bit rate and that the
// host pulses the first-half strobe before the second-half strobe.
module a429_tx_top #(
    parameter int DEPTH    = 8,
    parameter int TICKS    = 10,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] host_data,
    input  logic        load_first,
    input  logic        load_second,
    input  logic        par_even,
    input  logic        len32,
    output logic        tx_one,
    output logic        tx_zero,
    output logic        loop_bit,
    output logic        queue_empty
);
    import a429_pkg::*;

    logic [15:0]       low_half;
    logic [WORD_W-1:0] head_word;
    logic              take;

    // Holds the first half-word until the second strobe arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_half <= '0;
        else if (load_first) low_half <= host_data;
    end

    a429_fifo #(
        .W     (WORD_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (load_second),
        .wdata ({host_data, low_half}),
        .pop   (take),
        .rdata (head_word),
        .empty (queue_empty)
    );

    a429_ser #(
        .TICKS    (TICKS),
        .GAP_BITS (GAP_BITS)
    ) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .avail    (!queue_empty),
        .word     (head_word),
        .len32    (len32),
        .par_even (par_even),
        .take     (take),
        .tx_one   (tx_one),
        .tx_zero  (tx_zero),
        .loop_bit (loop_bit)
    );

    // R4: the serializer only takes a word while the queue reports data
    a_r4_take_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !queue_empty);

endmodule

// File: tb/a429_tx_top_tb.sv
// Bench: a vector table walked by one loop, then directed reset, gap and overflow tests.
module a429_tx_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_data = '0;
    logic        load_first = 1'b0;
    logic        load_second = 1'b0;
    logic        par_even = 1'b0;
    logic        len32 = 1'b1;
    logic        tx_one, tx_zero, loop_bit, queue_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    a429_tx_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data   (host_data),
        .load_first  (load_first),
        .load_second (load_second),
        .par_even    (par_even),
        .len32       (len32),
        .tx_one      (tx_one),
        .tx_zero     (tx_zero),
        .loop_bit    (loop_bit),
        .queue_empty (queue_empty)
    );

    // Vector: {par_even, len32, upper half, lower half}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b1, 16'h8000, 16'h00A5},
        {1'b1, 1'b1, 16'h1234, 16'h5678},
        {1'b0, 1'b0, 16'hFFFF, 16'hFFFF},
        {1'b1, 1'b0, 16'hAB00, 16'h0001},
        {1'b0, 1'b1, 16'h0000, 16'h0000},
        {1'b1, 1'b1, 16'h7FFF, 16'hFF80}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bits in send order, from the requirements alone.
    function automatic logic [31:0] expect_seq(input logic [31:0] w, input logic l32, input logic pe);
        logic [31:0] e;
        int          n;
        logic        ones;
        e    = '0;
        n    = l32 ? 32 : 25;
        ones = 1'b0;
        for (int k = 0; k < n - 1; k++) begin
            e[k] = (k < 8) ? w[7 - k] : w[k];
            ones = ones ^ w[k];
        end
        e[n - 1] = pe ? ones : ~ones;
        return e;
    endfunction

    task automatic push(input logic [31:0] w);
        load_first = 1'b1;
        host_data  = w[15:0];
        @(negedge clk);
        load_first  = 1'b0;
        load_second = 1'b1;
        host_data   = w[31:16];
        @(negedge clk);
        load_second = 1'b0;
    endtask

    // Waits for the first active clock, then reads n cells; returns the wait and the bits.
    task automatic capture(input int n, output logic [31:0] bits, output int waited, output bit shape_ok);
        bits     = '0;
        waited   = 0;
        shape_ok = 1'b1;
        while (!(tx_one || tx_zero) && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        for (int k = 0; k < n; k++) begin
            logic b;
            b = tx_one;
            bits[k] = b;
            if (tx_one == tx_zero || loop_bit != b) shape_ok = 1'b0;
            repeat (5) @(negedge clk);
            if (tx_one || tx_zero || loop_bit != b) shape_ok = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got, exp_s;
        int          waited, n;
        bit          shp;

        // R1: reset state, both during reset and just after release
        repeat (3) @(negedge clk);
        check(!tx_one && !tx_zero && !loop_bit && queue_empty, "R1 in reset",
              {tx_one, tx_zero, loop_bit, queue_empty}, 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_one && !tx_zero && !loop_bit && queue_empty, "R1 after reset",
              {tx_one, tx_zero, loop_bit, queue_empty}, 4'b0001);

        // Table walk: R2 assembly, R5 order and start, R6 shape, R7 parity, R8 length, R10 loopback
        for (int v = 0; v < 6; v++) begin
            par_even = VEC[v][33];
            len32    = VEC[v][32];
            n        = VEC[v][32] ? 32 : 25;
            exp_s    = expect_seq(VEC[v][31:0], VEC[v][32], VEC[v][33]);
            push(VEC[v][31:0]);
            check(!queue_empty, "R4 empty low after push", queue_empty, 0);
            capture(n, got, waited, shp);
            check(waited == 1, "R5 start one clock after push", waited, 1);
            check(got == exp_s, "R2 R7 R8 bit sequence", got, exp_s);
            check(shp, "R6 R10 cell shape and loopback", shp, 1);
            check(queue_empty, "R4 empty high after take", queue_empty, 1);
            // R8: in 25-bit mode no further cell follows the parity cell
            repeat (45) @(negedge clk);
            check(!tx_one && !tx_zero, "R8 R9 line null after word", {tx_one, tx_zero}, 0);
        end

        // R9: a queued second word starts exactly 40 clocks after the first word's last cell
        par_even = 1'b0;
        len32    = 1'b1;
        fork
            begin
                push(32'hC3C3_0F1E);
                repeat (20) @(negedge clk);
                push(32'h0102_03F0);
            end
            begin
                capture(32, got, waited, shp);
                check(got == expect_seq(32'hC3C3_0F1E, 1'b1, 1'b0), "R5 first of pair",
                      got, expect_seq(32'hC3C3_0F1E, 1'b1, 1'b0));
                capture(32, got, waited, shp);
                check(waited == 40, "R9 gap length", waited, 40);
                check(got == expect_seq(32'h0102_03F0, 1'b1, 1'b0), "R5 second of pair",
                      got, expect_seq(32'h0102_03F0, 1'b1, 1'b0));
            end
        join
        repeat (60) @(negedge clk);

        // R3: eleven pushes; one is taken at once, eight queue, two are dropped
        fork
            begin
                for (int i = 0; i < 11; i++) push({16'hA000 + 16'(i), 8'h00, 8'(i + 1)});
            end
            begin
                for (int i = 0; i < 9; i++) begin
                    logic [31:0] wexp;
                    wexp = {16'hA000 + 16'(i), 8'h00, 8'(i + 1)};
                    capture(32, got, waited, shp);
                    check(got == expect_seq(wexp, 1'b1, 1'b0), "R3 R5 queued word in order",
                          got, expect_seq(wexp, 1'b1, 1'b0));
                end
            end
        join
        waited = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (tx_one || tx_zero) waited++;
        end
        check(waited == 0, "R3 dropped words never sent", waited, 0);
        check(queue_empty, "R4 empty after drain", queue_empty, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule